// File: doc/BRIEF.md
# Diagnostic Output Signal Selector

This block drives one diagnostic output pin from a choice of internal status signals. A 4-bit mode field picks the source. The field is written through the register interface and loaded when a write strobe is given. The sources are the regulator-ready flag, the PLL digital lock-detect flag, and the narrow pulse from the reference divider. A further source is a half-rate square wave made by toggling a flip-flop on each of those pulses. The last group is four supply-threshold comparator results, one chosen per code.

The comparators, the regulator, the lock detector and the reference divider sit outside the block. Their results arrive as digital inputs that are synchronous to the system clock. The block holds the mode decode, the toggle flip-flop, the power-up default and a final output register. Because of that output register, the pin never glitches when the mode changes. After reset the pin shows regulator-ready, which also signals that the register interface is live.

Top module: `diag_selector`

## Requirements
- R1: While rst_n is low at a rising clock edge, diag_out is low after that edge, the mode register takes code 0001 and the half-rate flip-flop clears.
- R2: The mode register loads mode_in only at an edge where mode_wr is high. A value on mode_in with mode_wr low has no effect on diag_out.
- R3: Codes 1010, 1011, 1100 and 1101 select batt_cmp[0], [1], [2] and [3]. These are the comparators for supply above 3.25 V, 3.0 V, 2.75 V and 2.35 V. Each input is high when the supply is above its threshold.
- R4: Code 0001 selects reg_ready. This is the mode after reset.
- R5: Code 0011 selects lock_det.
- R6: Code 0100 selects ref_pulse, the reference-divider output pulse.
- R7: Code 0101 selects the half-rate flip-flop. The flip-flop inverts at every edge where ref_pulse is high and holds otherwise.
- R8: Every code not listed in R3 to R7 drives diag_out low.
- R9: diag_out is registered. After edge t it equals the selection made by the mode register and the source values held just before edge t, so a newly written mode shows at the second edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_wr | input | 1 | Load strobe for the mode register |
| mode_in | input | 4 | Mode code from the function register |
| reg_ready | input | 1 | Regulator-ready flag |
| lock_det | input | 1 | PLL digital lock-detect flag |
| ref_pulse | input | 1 | Reference-divider output pulse, one clock wide per period |
| batt_cmp | input | 4 | Supply comparator results, index 0 = highest threshold |
| diag_out | output | 1 | Registered diagnostic output |

## Verification
A source change or a new flip-flop value is due one edge after it is presented. A written mode is due two edges after the strobe: one edge to load the register and one to pass through the output register. For the half-rate source, the pulse that toggles the flip-flop at edge t shows on the pin at edge t+1. The bench drives every input on the falling edge. A behavioural model advances on each rising edge using those same settled inputs, and the pin is compared with the model on the next falling edge, so each latency is counted in full and never sampled at an edge.

// File: rtl/diag_sel_pkg.sv
// Package: mode codes and sizes shared by the diagnostic selector.
// Assumes a 4-bit mode field with the battery codes in one ascending run.
package diag_sel_pkg;
    localparam int MODE_W = 4;
    localparam int N_BATT = 4;

    localparam logic [MODE_W-1:0] MODE_REGRDY = 4'b0001;
    localparam logic [MODE_W-1:0] MODE_LOCK   = 4'b0011;
    localparam logic [MODE_W-1:0] MODE_REFP   = 4'b0100;
    localparam logic [MODE_W-1:0] MODE_HALF   = 4'b0101;
    localparam logic [MODE_W-1:0] MODE_BATT0  = 4'b1010;
endpackage

// File: rtl/diag_mode_reg.sv
// Mode register: holds the selector code and loads only on a write strobe.
// Assumes mode_wr and mode_in are synchronous to clk. Reset gives RST_CODE.
module diag_mode_reg #(
    parameter int W = 4,
    parameter logic [W-1:0] RST_CODE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    // Load on the strobe, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= RST_CODE;
        else if (wr) q <= din;
    end
endmodule

// File: rtl/diag_half_rate.sv
// Half-rate divider: a toggle flip-flop that inverts on each reference pulse.
// Assumes the pulse is one clock wide per period and synchronous to clk.
module diag_half_rate (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse,
    output logic q
);
    // Invert on every pulse; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= 1'b0;
        else if (pulse) q <= ~q;
    end
endmodule

// File: rtl/diag_out_mux.sv
// Output mux: decodes the mode code and registers the chosen source.
// Unassigned codes give a low output. The battery codes run upward from
// MODE_BATT0, one per comparator.
module diag_out_mux
    import diag_sel_pkg::*;
#(
    parameter int W  = MODE_W,
    parameter int NB = N_BATT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  mode,
    input  logic          reg_ready,
    input  logic          lock_det,
    input  logic          ref_pulse,
    input  logic          half_q,
    input  logic [NB-1:0] batt_cmp,
    output logic          out_q
);
    logic sel_d;

    // Decode the code into the selected source level.
    always_comb begin
        sel_d = 1'b0;
        case (mode)
            MODE_REGRDY: sel_d = reg_ready;
            MODE_LOCK:   sel_d = lock_det;
            MODE_REFP:   sel_d = ref_pulse;
            MODE_HALF:   sel_d = half_q;
            default: begin
                for (int i = 0; i < NB; i++) begin
                    if (mode == W'(int'(MODE_BATT0) + i)) sel_d = batt_cmp[i];
                end
            end
        endcase
    end

    // Register the selection so the pin cannot glitch on a mode change.
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= sel_d;
    end
endmodule

// File: rtl/diag_selector.sv
// Top: diagnostic output selector. Holds the mode register, the half-rate
// toggle and the registered output mux. All inputs are assumed synchronous
// to clk. Reset is synchronous and active low.
module diag_selector
    import diag_sel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_in,
    input  logic              reg_ready,
    input  logic              lock_det,
    input  logic              ref_pulse,
    input  logic [N_BATT-1:0] batt_cmp,
    output logic              diag_out
);
    logic [MODE_W-1:0] mode_q;
    logic              half_q;

    diag_mode_reg #(.W(MODE_W), .RST_CODE(MODE_REGRDY)) u_mode (
        .clk(clk), .rst_n(rst_n), .wr(mode_wr), .din(mode_in), .q(mode_q)
    );

    diag_half_rate u_half (
        .clk(clk), .rst_n(rst_n), .pulse(ref_pulse), .q(half_q)
    );

    diag_out_mux #(.W(MODE_W), .NB(N_BATT)) u_mux (
        .clk(clk), .rst_n(rst_n), .mode(mode_q), .reg_ready(reg_ready),
        .lock_det(lock_det), .ref_pulse(ref_pulse), .half_q(half_q),
        .batt_cmp(batt_cmp), .out_q(diag_out)
    );
endmodule

// File: rtl/diag_selector_chk.sv
// Checker: temporal properties of the diagnostic selector, bound to the top.
module diag_selector_chk
    import diag_sel_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              mode_wr,
    input logic [MODE_W-1:0] mode_in,
    input logic [MODE_W-1:0] mode_q,
    input logic              half_q,
    input logic              reg_ready,
    input logic              lock_det,
    input logic              ref_pulse,
    input logic [N_BATT-1:0] batt_cmp,
    input logic              diag_out
);
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!diag_out && !half_q && mode_q == MODE_REGRDY));

    a_r2_hold_mode: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_wr |=> $stable(mode_q));

    a_r2_load_mode: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> mode_q == $past(mode_in));

    a_r3_batt_hi: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q == 4'b1010 |=> diag_out == $past(batt_cmp[0]));

    a_r3_batt_lo: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q == 4'b1101 |=> diag_out == $past(batt_cmp[3]));

    a_r4_regrdy: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q == MODE_REGRDY |=> diag_out == $past(reg_ready));

    a_r5_lock: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q == MODE_LOCK |=> diag_out == $past(lock_det));

    a_r6_refp: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q == MODE_REFP |=> diag_out == $past(ref_pulse));

    a_r7_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pulse |=> half_q != $past(half_q));

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_pulse |=> $stable(half_q));

    a_r8_unassigned: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 4'b0000 || mode_q == 4'b1111 || mode_q == 4'b0111)
        |=> !diag_out);
endmodule

bind diag_selector diag_selector_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_in(mode_in),
    .mode_q(mode_q), .half_q(half_q), .reg_ready(reg_ready),
    .lock_det(lock_det), .ref_pulse(ref_pulse), .batt_cmp(batt_cmp),
    .diag_out(diag_out)
);

// File: tb/sim_diag_selector.sv
// Bench: behavioural model advanced on each rising edge, compared on the
// falling edge. Inputs change on the falling edge only.
module sim_diag_selector;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_wr = 1'b0;
    logic [3:0] mode_in = 4'b0;
    logic       reg_ready = 1'b0;
    logic       lock_det = 1'b0;
    logic       ref_pulse = 1'b0;
    logic [3:0] batt_cmp = 4'b0;
    logic       diag_out;

    int    vectors = 0;
    int    errors = 0;
    int    cycles = 0;
    string phase = "R1";
    bit    done = 1'b0;

    int m_mode = 1;
    bit m_half = 1'b0;
    bit m_out = 1'b0;

    always #10 clk = ~clk;

    diag_selector u0 (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_in(mode_in),
        .reg_ready(reg_ready), .lock_det(lock_det), .ref_pulse(ref_pulse),
        .batt_cmp(batt_cmp), .diag_out(diag_out)
    );

    // Reference model: what each requirement says the pin should show.
    function automatic bit pick(int md, bit hf);
        case (md)
            1:  return reg_ready;
            3:  return lock_det;
            4:  return ref_pulse;
            5:  return hf;
            10: return batt_cmp[0];
            11: return batt_cmp[1];
            12: return batt_cmp[2];
            13: return batt_cmp[3];
            default: return 1'b0;
        endcase
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_out = 1'b0; m_mode = 1; m_half = 1'b0;
        end else begin
            m_out = pick(m_mode, m_half);
            if (ref_pulse) m_half = ~m_half;
            if (mode_wr) m_mode = int'(mode_in);
        end
    end

    // Compare on every falling edge.
    always @(negedge clk) begin
        if (!done && cycles > 0) begin
            vectors++;
            if (diag_out !== m_out) begin
                errors++;
                $display("FAIL %s mode=%0d: diag_out=%b expected %b", phase, m_mode, diag_out, m_out);
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_mode(int code);
        @(negedge clk);
        mode_in = 4'(code); mode_wr = 1'b1;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic wiggle(int n);
        repeat (n) begin
            @(negedge clk);
            reg_ready = 1'($urandom);
            lock_det  = 1'($urandom);
            ref_pulse = 1'($urandom);
            batt_cmp  = 4'($urandom);
        end
    endtask

    initial begin
        // R1: reset state with active sources.
        phase = "R1";
        reg_ready = 1'b1; lock_det = 1'b1; batt_cmp = 4'hF;
        step(4);
        rst_n = 1'b1;
        // R4: default mode after reset shows regulator-ready.
        phase = "R4";
        wiggle(20);
        // R2: a mode value with no strobe is ignored.
        phase = "R2";
        mode_in = 4'b0011; lock_det = 1'b0; reg_ready = 1'b1;
        step(5);
        wiggle(10);
        // R3: each battery code.
        phase = "R3";
        for (int c = 10; c <= 13; c++) begin
            write_mode(c);
            wiggle(12);
        end
        phase = "R5";
        write_mode(3); wiggle(15);
        phase = "R6";
        write_mode(4); wiggle(15);
        // R7: regular pulse train, then an irregular one.
        phase = "R7";
        write_mode(5);
        for (int k = 0; k < 12; k++) begin
            @(negedge clk); ref_pulse = (k % 3 == 0);
        end
        wiggle(20);
        // R8: every unassigned code.
        phase = "R8";
        reg_ready = 1'b1; lock_det = 1'b1; batt_cmp = 4'hF; ref_pulse = 1'b1;
        for (int c = 0; c < 16; c++) begin
            if (!(c == 1 || c == 3 || c == 4 || c == 5 || (c >= 10 && c <= 13))) begin
                write_mode(c);
                step(3);
            end
        end
        // R9: mode written every cycle with changing sources.
        phase = "R9";
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            mode_in = 4'($urandom); mode_wr = 1'($urandom);
            reg_ready = 1'($urandom); lock_det = 1'($urandom);
            ref_pulse = 1'($urandom); batt_cmp = 4'($urandom);
        end
        mode_wr = 1'b0;
        // R1: reset mid-run restores defaults.
        phase = "R1";
        write_mode(5);
        @(negedge clk); rst_n = 1'b0;
        step(3);
        rst_n = 1'b1;
        phase = "R4";
        wiggle(10);
        step(1);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: diag_out=%b expected run end", diag_out);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule